// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port with Edge Interrupts

This block is a general-purpose pin port sitting on a simple synchronous register bus. The bus carries a byte offset and an access-size code. Software configures each pin as an input or a driven output and sets the value driven on output pins. For every input pin, it also selects whether a rising or a falling transition is of interest. A matching transition on an input pin that is not masked latches a sticky status bit. The OR of all status bits appears on a single registered level interrupt line. Software clears status bits by writing ones to them.

The pins arrive already synchronised. The block registers them once more and finds transitions by comparing this sampled value with the sample taken one clock earlier. Reading the input-data register returns the sampled pins gated by a per-pin enable register. Bus reads are answered on the clock after the request. Only half-word (16-bit) accesses are accepted.

Top module: `epg_gpio`

## Requirements
- R1: An accepted read returns its register on `bus_rdata` in the cycle after the request. The offsets are 0x00 input data, 0x04 output value, 0x08 direction, 0x0C polarity, 0x10 mask, 0x14 status and 0x18 pin enable. Any other offset reads as zero, and `bus_rdata` is zero in every cycle that does not follow an accepted read.
- R2: `pin_oe` is the inverse of the direction register (direction 1 = input, 0 = driven output). `pin_out` carries the output-value register. A write to either register shows on the pins after the clock edge that accepts it.
- R3: With polarity bit 1, a 0-to-1 change of a sampled input pin sets its status bit. The bit is set on the clock edge after the one that sampled the new level.
- R4: With polarity bit 0, a 1-to-0 change of a sampled input pin sets its status bit, with the same timing as R3. The opposite transition sets nothing.
- R5: A transition sets no status bit on a pin whose direction bit is 0 or whose mask bit is 1.
- R6: Writing offset 0x14 clears each status bit written as 1 and leaves the other bits alone. If a transition sets a bit on the same edge that a write clears it, the bit stays set.
- R7: `irq` is a registered output equal to the OR of the status bits. It rises on the same edge as the first status bit and falls only when all status bits are zero.
- R8: `pin_in` is sampled on every clock edge. A read of offset 0x00 returns that sample ANDed with the pin-enable register.
- R9: An access whose `bus_size` is not 1 (0 = byte, 1 = half-word, 2 = word) is rejected: a write changes nothing and a read returns zero. A write to offset 0x00 changes nothing.
- R10: After reset, output value, direction, polarity, mask and pin enable are all ones. The input sample, status and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 5 | Byte offset of the register |
| bus_size | input | 2 | Access size code: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after an accepted read |
| pin_in | input | 16 | Synchronised input pin levels |
| pin_out | output | 16 | Output pin values |
| pin_oe | output | 16 | Per-pin drive enable |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that every bus and pin input is a known 0 or 1 at each rising edge. They also assume that `bus_size` and `bus_ofs` carry meaning only while `bus_sel` is high. The bench satisfies both by changing every input only at the falling edge and by holding all inputs at defined values from time zero. During random phases, the select line and size code are sometimes left defined but unselected, which exercises the rejection paths without leaving the assumptions.

// File: rtl/epg_pkg.sv
package epg_pkg;

  localparam int unsigned OFS_W  = 5;
  localparam int unsigned SIZE_W = 2;
  localparam int unsigned N_CFG  = 5;

  localparam logic [SIZE_W-1:0] SIZE_HALF = 2'd1;

  localparam logic [OFS_W-1:0] OFS_DIN  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_DOUT = 5'h04;
  localparam logic [OFS_W-1:0] OFS_DIR  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_POL  = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_MSK  = 5'h10;
  localparam logic [OFS_W-1:0] OFS_STS  = 5'h14;
  localparam logic [OFS_W-1:0] OFS_PEN  = 5'h18;

  typedef enum logic [2:0] {
    R_NONE = 3'd0,
    R_DOUT = 3'd1,
    R_DIR  = 3'd2,
    R_POL  = 3'd3,
    R_MSK  = 3'd4,
    R_PEN  = 3'd5,
    R_DIN  = 3'd6,
    R_STS  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    reg_sel_e which;
  } bus_dec_t;

  // Configuration register index i (0..N_CFG-1) maps to select code i+1.
  function automatic reg_sel_e cfg_sel(input int unsigned idx);
    return reg_sel_e'(3'(idx + 1));
  endfunction

endpackage

// File: rtl/epg_decode.sv
module epg_decode
  import epg_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_ofs,
  input  logic [SIZE_W-1:0] bus_size,
  output bus_dec_t          dec
);

  logic accept;

  always_comb begin
    accept    = bus_sel && (bus_size == SIZE_HALF);
    dec.rd    = accept && !bus_we;
    dec.wr    = accept && bus_we;
    unique case (bus_ofs)
      OFS_DIN:  dec.which = R_DIN;
      OFS_DOUT: dec.which = R_DOUT;
      OFS_DIR:  dec.which = R_DIR;
      OFS_POL:  dec.which = R_POL;
      OFS_MSK:  dec.which = R_MSK;
      OFS_STS:  dec.which = R_STS;
      OFS_PEN:  dec.which = R_PEN;
      default:  dec.which = R_NONE;
    endcase
  end

endmodule

// File: rtl/epg_cfg_regs.sv
module epg_cfg_regs
  import epg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bus_dec_t     dec,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] dout_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] msk_q,
  output logic [N-1:0] pen_q
);

  localparam logic [N-1:0] RST_VAL = '1;

  logic [N-1:0] cfg_q [N_CFG];
  logic [N-1:0] cfg_d [N_CFG];
  logic         cfg_en [N_CFG];

  for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
    always_comb begin
      cfg_en[g] = dec.wr && (dec.which == cfg_sel(g));
      cfg_d[g]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= RST_VAL;
      end else if (cfg_en[g]) begin
        cfg_q[g] <= cfg_d[g];
      end
    end
  end

  assign dout_q = cfg_q[0];
  assign dir_q  = cfg_q[1];
  assign pol_q  = cfg_q[2];
  assign msk_q  = cfg_q[3];
  assign pen_q  = cfg_q[4];

endmodule

// File: rtl/epg_edge.sv
module epg_edge #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] msk,
  output logic [N-1:0] smp_q,
  output logic [N-1:0] hit
);

  logic [N-1:0] prv_q;
  logic [N-1:0] smp_d;
  logic [N-1:0] prv_d;

  always_comb begin
    smp_d = pin_in;
    prv_d = smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= smp_d;
      prv_q <= prv_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic rise;
    logic fall;
    logic armed;
    always_comb begin
      rise   = smp_q[g] & ~prv_q[g];
      fall   = ~smp_q[g] & prv_q[g];
      armed  = dir[g] & ~msk[g];
      hit[g] = armed & (pol[g] ? rise : fall);
    end
  end

endmodule

// File: rtl/epg_irq.sv
module epg_irq #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr_en,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] sts_q,
  output logic         irq_q
);

  logic [N-1:0] clr_mask;
  logic [N-1:0] sts_d;
  logic         sts_en;
  logic         irq_d;

  always_comb begin
    clr_mask = clr_en ? clr_bits : '0;
    // A new event wins over a simultaneous clear of the same bit.
    sts_d    = (sts_q & ~clr_mask) | hit;
    sts_en   = clr_en | (|hit);
    irq_d    = |sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else if (sts_en) begin
      sts_q <= sts_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/epg_gpio.sv
module epg_gpio
  import epg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_ofs,
  input  logic [SIZE_W-1:0] bus_size,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe,
  output logic              irq
);

  bus_dec_t     dec;
  logic [N-1:0] dout_q, dir_q, pol_q, msk_q, pen_q;
  logic [N-1:0] smp_q, hit, sts_q;
  logic         clr_en;
  logic [N-1:0] rd_mux, rd_d, rd_q;

  epg_decode u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_ofs  (bus_ofs),
    .bus_size (bus_size),
    .dec      (dec)
  );

  epg_cfg_regs #(.N(N)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec    (dec),
    .wdata  (bus_wdata),
    .dout_q (dout_q),
    .dir_q  (dir_q),
    .pol_q  (pol_q),
    .msk_q  (msk_q),
    .pen_q  (pen_q)
  );

  epg_edge #(.N(N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .dir    (dir_q),
    .pol    (pol_q),
    .msk    (msk_q),
    .smp_q  (smp_q),
    .hit    (hit)
  );

  assign clr_en = dec.wr && (dec.which == R_STS);

  epg_irq #(.N(N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr_en   (clr_en),
    .clr_bits (bus_wdata),
    .sts_q    (sts_q),
    .irq_q    (irq)
  );

  always_comb begin
    unique case (dec.which)
      R_DIN:   rd_mux = smp_q & pen_q;
      R_DOUT:  rd_mux = dout_q;
      R_DIR:   rd_mux = dir_q;
      R_POL:   rd_mux = pol_q;
      R_MSK:   rd_mux = msk_q;
      R_STS:   rd_mux = sts_q;
      R_PEN:   rd_mux = pen_q;
      default: rd_mux = '0;
    endcase
    rd_d = dec.rd ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign bus_rdata = rd_q;
  assign pin_out   = dout_q;
  assign pin_oe    = ~dir_q;

endmodule

// File: rtl/epg_checker.sv
module epg_checker
  import epg_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [OFS_W-1:0]  bus_ofs,
  input logic [SIZE_W-1:0] bus_size,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      bus_rdata,
  input logic [N-1:0]      pin_out,
  input logic [N-1:0]      pin_oe,
  input logic              irq,
  input logic [N-1:0]      sts,
  input logic [N-1:0]      hit,
  input logic [N-1:0]      dir,
  input logic [N-1:0]      msk
);

  logic ok_acc;
  assign ok_acc = bus_sel && (bus_size == SIZE_HALF);

  // R1: no accepted read, no data
  p_rdata_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_acc && !bus_we) |=> (bus_rdata == '0));

  // R2: direction write reaches the drive enables
  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_acc && bus_we && bus_ofs == OFS_DIR) |=> (pin_oe == ~$past(bus_wdata)));

  // R3: a detected event is latched
  p_event_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((sts & $past(hit)) == $past(hit)));

  // R5: newly set bits come only from unmasked input pins
  p_only_armed_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~($past(dir) & ~$past(msk))) == '0));

  // R6: write-one-to-clear, unless an event lands on the same bit
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_acc && bus_we && bus_ofs == OFS_STS)
      |=> ((sts & $past(bus_wdata) & ~$past(hit)) == '0));

  // R7: line equals OR of status
  p_irq_or_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|sts));

  // R9: rejected writes leave the pins alone
  p_badsize_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_size != SIZE_HALF) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind epg_gpio epg_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_ofs   (bus_ofs),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .sts       (sts_q),
  .hit       (hit),
  .dir       (dir_q),
  .msk       (msk_q)
);

// File: tb/epg_gpio_tb.sv
module epg_gpio_tb;

  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [4:0]    bus_ofs = '0;
  logic [1:0]    bus_size = 2'd1;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;
  logic          irq;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string tag = "R10";

  // reference state
  logic [N-1:0] m_smp, m_prv, m_out, m_dir, m_pol, m_msk, m_pen, m_sts, m_rd;
  logic         m_irq;

  always #5ns clk = ~clk;

  epg_gpio #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_ofs(bus_ofs), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  task automatic model_reset();
    m_smp = '0; m_prv = '0; m_sts = '0; m_irq = 1'b0; m_rd = '0;
    m_out = '1; m_dir = '1; m_pol = '1; m_msk = '1; m_pen = '1;
  endtask

  task automatic compare();
    vectors++;
    if (pin_out !== m_out) begin
      miscompares++;
      $display("FAIL %s/R2 pin_out act=%h exp=%h", tag, pin_out, m_out);
    end
    if (pin_oe !== ~m_dir) begin
      miscompares++;
      $display("FAIL %s/R2 pin_oe act=%h exp=%h", tag, pin_oe, ~m_dir);
    end
    if (irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s/R7 irq act=%b exp=%b", tag, irq, m_irq);
    end
    if (bus_rdata !== m_rd) begin
      miscompares++;
      $display("FAIL %s/R1 rdata act=%h exp=%h", tag, bus_rdata, m_rd);
    end
  endtask

  // One clock: inputs already driven; model advances with the edge.
  task automatic tick();
    bit           ok;
    logic [N-1:0] hitv, clr, nsts;
    ok = bus_sel && (bus_size == 2'd1);
    @(posedge clk);
    hitv = '0;
    for (int i = 0; i < N; i++) begin
      if (m_dir[i] && !m_msk[i]) begin
        if (m_pol[i] && m_smp[i] && !m_prv[i]) hitv[i] = 1'b1;
        if (!m_pol[i] && !m_smp[i] && m_prv[i]) hitv[i] = 1'b1;
      end
    end
    clr  = (ok && bus_we && bus_ofs == 5'h14) ? bus_wdata : '0;
    nsts = (m_sts & ~clr) | hitv;
    m_rd = '0;
    if (ok && !bus_we) begin
      case (bus_ofs)
        5'h00: m_rd = m_smp & m_pen;
        5'h04: m_rd = m_out;
        5'h08: m_rd = m_dir;
        5'h0C: m_rd = m_pol;
        5'h10: m_rd = m_msk;
        5'h14: m_rd = m_sts;
        5'h18: m_rd = m_pen;
        default: m_rd = '0;
      endcase
    end
    if (ok && bus_we) begin
      case (bus_ofs)
        5'h04: m_out = bus_wdata;
        5'h08: m_dir = bus_wdata;
        5'h0C: m_pol = bus_wdata;
        5'h10: m_msk = bus_wdata;
        5'h18: m_pen = bus_wdata;
        default: ;
      endcase
    end
    m_prv = m_smp;
    m_smp = pin_in;
    m_sts = nsts;
    m_irq = (nsts != '0);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n = 1);
    for (int i = 0; i < n; i++) begin
      bus_sel = 1'b0; bus_we = 1'b0;
      tick();
    end
  endtask

  task automatic wr(logic [4:0] ofs, logic [N-1:0] d, logic [1:0] sz = 2'd1);
    bus_sel = 1'b1; bus_we = 1'b1; bus_ofs = ofs; bus_wdata = d; bus_size = sz;
    tick();
    bus_sel = 1'b0; bus_we = 1'b0; bus_size = 2'd1;
  endtask

  task automatic rd(logic [4:0] ofs, logic [1:0] sz = 2'd1);
    bus_sel = 1'b1; bus_we = 1'b0; bus_ofs = ofs; bus_size = sz;
    tick();
    bus_sel = 1'b0; bus_size = 2'd1;
    idle(1);
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) rd(5'(a * 4));
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R10";
    compare();
    rst_n = 1'b1;
    idle(2);
    read_all();

    tag = "R1";
    wr(5'h04, 16'h5AC3);
    wr(5'h08, 16'h00FF);
    wr(5'h0C, 16'h000F);
    wr(5'h10, 16'h0000);
    wr(5'h18, 16'hFFFF);
    read_all();
    rd(5'h02); rd(5'h1C); rd(5'h1F);

    tag = "R2";
    wr(5'h04, 16'h1234);
    wr(5'h08, 16'hF00F);
    wr(5'h08, 16'h00FF);

    tag = "R3";
    pin_in = 16'h000F; idle(3); rd(5'h14);

    tag = "R4";
    pin_in = 16'h00FF; idle(3); rd(5'h14);
    pin_in = 16'h000F; idle(3); rd(5'h14);

    tag = "R6";
    wr(5'h14, 16'h00F0); rd(5'h14);
    wr(5'h14, 16'h0000); rd(5'h14);
    wr(5'h14, 16'h000F); rd(5'h14);
    pin_in = 16'h0000; idle(2);
    pin_in = 16'h0001; idle(1);
    wr(5'h14, 16'h0001);        // event lands on this edge
    rd(5'h14);
    wr(5'h14, 16'hFFFF); rd(5'h14);

    tag = "R5";
    wr(5'h10, 16'h0003);
    pin_in = 16'hFF03; idle(3);
    pin_in = 16'h0000; idle(3);
    rd(5'h14);
    wr(5'h10, 16'h0000);

    tag = "R7";
    pin_in = 16'h0004; idle(3);
    wr(5'h14, 16'h0004); idle(2);
    pin_in = 16'h0000; idle(2);

    tag = "R8";
    wr(5'h18, 16'h0F0F);
    pin_in = 16'hFFFF; idle(2);
    rd(5'h00);
    pin_in = 16'hA5A5; idle(2);
    rd(5'h00);
    wr(5'h18, 16'hFFFF);
    rd(5'h00);

    tag = "R9";
    wr(5'h04, 16'h0000, 2'd0);
    wr(5'h08, 16'hFFFF, 2'd2);
    wr(5'h14, 16'hFFFF, 2'd0);
    wr(5'h00, 16'h0000);
    rd(5'h04, 2'd0); rd(5'h08, 2'd2); rd(5'h14, 2'd3);
    read_all();

    tag = "R3";
    for (int i = 0; i < 600; i++) begin
      pin_in   = 16'($urandom);
      bus_sel  = ($urandom % 3) != 0;
      bus_we   = $urandom % 2;
      bus_ofs  = 5'(($urandom % 9) * 4);
      bus_size = ($urandom % 5 == 0) ? 2'($urandom) : 2'd1;
      bus_wdata = 16'($urandom);
      tick();
    end
    idle(2);
    read_all();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired in section %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule